// File: doc/BRIEF.md
# Multi-format floating-point classifier

This block sorts floating-point operands into classes. An operand sits in a register of parameterised width (32 or 64 bits). A 3-bit selector chooses one of five encodings: three IEEE binary formats and two small non-IEEE formats. For every value the block returns a one-hot 10-bit class mask and an 8-bit set of info flags. The floating-point unit uses the result for class queries, and the operand checks that run ahead of arithmetic use it too.

In scalar mode one value is taken from the low bits of the register. The block also checks that the unused upper bits form a valid NaN box. A value with a broken box is reported as a quiet NaN. In vector mode the register is split into as many packed lanes of the selected format as fit, and each lane is classified on its own. A single registered output stage with a valid/ready handshake holds the result until it is taken.

Top module: `fpcls_top`

## Requirements
- R1: The format codes on `fmt_i` are 0 = 32-bit (8 exponent, 23 mantissa bits), 1 = 64-bit (11, 52), 2 = 16-bit (5, 10), 3 = 8-bit (5, 2) and 4 = alternate 16-bit (8, 7). The format width is exponent + mantissa + 1. Codes 5 to 7 are unsupported, and so is a format wider than the register. An unsupported code sets `fmt_err_o` to 1 and drives every lane's mask and info to zero, in the same output beat as the result. A supported code gives `fmt_err_o` = 0.
- R2: The class mask of lane l is `class_mask_o[10*l +: 10]`. For an active lane exactly one bit is set: bit 0 is negative infinity, 1 negative normal, 2 negative subnormal, 3 negative zero, 4 positive zero, 5 positive subnormal, 6 positive normal, 7 positive infinity, 8 signalling NaN and 9 quiet NaN.
- R3: The info flags of lane l are `info_o[8*l +: 8]`, with bit 0 normal, 1 subnormal, 2 zero, 3 infinity, 4 NaN, 5 signalling, 6 quiet and 7 boxed. The bit order is part of the interface.
- R4: A value whose exponent field is all ones is a NaN when its mantissa is nonzero and an infinity when its mantissa is zero. A NaN is quiet when the top mantissa bit is 1 and signalling when it is 0. The sign bit has no effect on the class of a NaN.
- R5: A zero exponent field with a zero mantissa is a zero, and with a nonzero mantissa it is a subnormal. Every other value is normal. The class takes its sign from the top bit of the value.
- R6: In scalar mode (`vec_en_i` = 0) only lane 0 is active. It classifies the low format-width bits of the register. All other lanes give zero mask and zero info.
- R7: In scalar mode a value narrower than the register is boxed only when every register bit above it is 1, and a full-width value is always boxed. A boxed value has info bit 7 set. A value that is not boxed gives mask bit 9 only and info bits 4 and 6 only.
- R8: In vector mode (`vec_en_i` = 1) the lane count is the register width divided by the format width. Lane l classifies register bits [l*FW +: FW], and each active lane has its boxed flag set. Lanes at or beyond the lane count give zero mask and zero info.
- R9: An input is taken on a clock edge where `in_valid_i` and `in_ready_o` are both high. Its result is on the outputs with `out_valid_o` high from that edge on. `in_ready_o` equals `out_ready_i` OR NOT `out_valid_o`. Without a new input, `out_valid_o` falls on an edge where `out_ready_i` is high.
- R10: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o`, the masks, the info and `fmt_err_o` hold stable.
- R11: While `rst_ni` is low, `out_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand offered |
| in_ready_o | output | 1 | Operand can be taken |
| fmt_i | input | 3 | Format code |
| vec_en_i | input | 1 | 1 = packed lanes, 0 = one scalar value |
| operand_i | input | WIDTH | Operand register |
| out_valid_o | output | 1 | Result available |
| out_ready_i | input | 1 | Downstream takes the result |
| class_mask_o | output | 10*WIDTH/8 | Per-lane one-hot class masks |
| info_o | output | 8*WIDTH/8 | Per-lane info flags |
| fmt_err_o | output | 1 | Unsupported format code in this result |

## Verification
Scalar operands of each format are hand-picked to reach every class and its sign: infinities, zeros, subnormals, normals and both NaN kinds. This separates sign handling, the exponent decode and the use of the top mantissa bit for quiet and signalling NaNs. Upper-bit patterns that are fully ones, all zeros and one bit short of all ones test the boxing check against a full-width value, which is never boxed-tested. Packed operands in each format mix classes across lanes, so a lane-offset or lane-count error moves a class into the wrong slot or lights an inactive lane. Unsupported codes, and a stalled output receiving a new operand, test the error path and the hold behaviour.

// File: rtl/fpcls_pkg.sv
package fpcls_pkg;

  localparam int unsigned NUM_FMTS  = 5;
  localparam int unsigned FMT_SEL_W = 3;
  localparam int unsigned CLASS_W   = 10;
  localparam int unsigned INFO_W    = 8;

  // class mask bit positions
  localparam int unsigned CLS_NEG_INF  = 0;
  localparam int unsigned CLS_NEG_NORM = 1;
  localparam int unsigned CLS_NEG_SUB  = 2;
  localparam int unsigned CLS_NEG_ZERO = 3;
  localparam int unsigned CLS_POS_ZERO = 4;
  localparam int unsigned CLS_POS_SUB  = 5;
  localparam int unsigned CLS_POS_NORM = 6;
  localparam int unsigned CLS_POS_INF  = 7;
  localparam int unsigned CLS_SNAN     = 8;
  localparam int unsigned CLS_QNAN     = 9;

  // info flag bit positions
  localparam int unsigned INF_NORMAL = 0;
  localparam int unsigned INF_SUB    = 1;
  localparam int unsigned INF_ZERO   = 2;
  localparam int unsigned INF_INF    = 3;
  localparam int unsigned INF_NAN    = 4;
  localparam int unsigned INF_SIG    = 5;
  localparam int unsigned INF_QUIET  = 6;
  localparam int unsigned INF_BOXED  = 7;

  function automatic int unsigned fmt_exp_w(int unsigned f);
    case (f)
      0: return 8;
      1: return 11;
      2: return 5;
      3: return 5;
      4: return 8;
      default: return 0;
    endcase
  endfunction

  function automatic int unsigned fmt_man_w(int unsigned f);
    case (f)
      0: return 23;
      1: return 52;
      2: return 10;
      3: return 2;
      4: return 7;
      default: return 0;
    endcase
  endfunction

  function automatic int unsigned fmt_width(int unsigned f);
    return fmt_exp_w(f) + fmt_man_w(f) + 1;
  endfunction

  function automatic int unsigned min_fmt_width();
    int unsigned res;
    res = fmt_width(0);
    for (int unsigned f = 1; f < NUM_FMTS; f++)
      if (fmt_width(f) < res) res = fmt_width(f);
    return res;
  endfunction

endpackage

// File: rtl/fpcls_lane.sv
module fpcls_lane
  import fpcls_pkg::*;
#(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0]  val_i,
  input  logic                  boxed_i,
  output logic [CLASS_W-1:0]    mask_o,
  output logic [INFO_W-1:0]     info_o
);

  logic             sign;
  logic [EXP_W-1:0] expo;
  logic [MAN_W-1:0] man;
  logic             exp_ones, exp_zero, man_zero;

  assign sign     = val_i[EXP_W+MAN_W];
  assign expo     = val_i[EXP_W+MAN_W-1:MAN_W];
  assign man      = val_i[MAN_W-1:0];
  assign exp_ones = &expo;
  assign exp_zero = ~|expo;
  assign man_zero = ~|man;

  always_comb begin
    mask_o = '0;
    info_o = '0;
    if (!boxed_i) begin
      // broken box reads as quiet NaN
      mask_o[CLS_QNAN]  = 1'b1;
      info_o[INF_NAN]   = 1'b1;
      info_o[INF_QUIET] = 1'b1;
    end else begin
      info_o[INF_BOXED] = 1'b1;
      if (exp_ones && !man_zero) begin
        info_o[INF_NAN] = 1'b1;
        if (man[MAN_W-1]) begin
          mask_o[CLS_QNAN]  = 1'b1;
          info_o[INF_QUIET] = 1'b1;
        end else begin
          mask_o[CLS_SNAN] = 1'b1;
          info_o[INF_SIG]  = 1'b1;
        end
      end else if (exp_ones) begin
        info_o[INF_INF] = 1'b1;
        if (sign) mask_o[CLS_NEG_INF] = 1'b1;
        else      mask_o[CLS_POS_INF] = 1'b1;
      end else if (exp_zero && man_zero) begin
        info_o[INF_ZERO] = 1'b1;
        if (sign) mask_o[CLS_NEG_ZERO] = 1'b1;
        else      mask_o[CLS_POS_ZERO] = 1'b1;
      end else if (exp_zero) begin
        info_o[INF_SUB] = 1'b1;
        if (sign) mask_o[CLS_NEG_SUB] = 1'b1;
        else      mask_o[CLS_POS_SUB] = 1'b1;
      end else begin
        info_o[INF_NORMAL] = 1'b1;
        if (sign) mask_o[CLS_NEG_NORM] = 1'b1;
        else      mask_o[CLS_POS_NORM] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/fpcls_slice.sv
module fpcls_slice
  import fpcls_pkg::*;
#(
  parameter int unsigned WIDTH   = 64,
  parameter int unsigned FMT_IDX = 0,
  parameter int unsigned LANES   = 8
) (
  input  logic [WIDTH-1:0]          op_i,
  input  logic                      vec_en_i,
  output logic [LANES*CLASS_W-1:0]  mask_o,
  output logic [LANES*INFO_W-1:0]   info_o,
  output logic                      supported_o
);

  localparam int unsigned EW     = fmt_exp_w(FMT_IDX);
  localparam int unsigned MW     = fmt_man_w(FMT_IDX);
  localparam int unsigned FW     = EW + MW + 1;
  localparam int unsigned VLANES = WIDTH / FW;

  if (FW > WIDTH) begin : g_unsup
    assign mask_o      = '0;
    assign info_o      = '0;
    assign supported_o = 1'b0;
  end else begin : g_sup
    logic box_ok;

    assign supported_o = 1'b1;

    if (FW < WIDTH) begin : g_box
      assign box_ok = &op_i[WIDTH-1:FW];
    end else begin : g_full
      assign box_ok = 1'b1;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
      if (l < VLANES) begin : g_act
        localparam bit IS_L0 = (l == 0);
        logic [CLASS_W-1:0] m;
        logic [INFO_W-1:0]  f;
        logic               active;

        fpcls_lane #(
          .EXP_W (EW),
          .MAN_W (MW)
        ) u_lane (
          .val_i   (op_i[l*FW +: FW]),
          .boxed_i (vec_en_i | box_ok),
          .mask_o  (m),
          .info_o  (f)
        );

        assign active = vec_en_i | IS_L0;
        assign mask_o[l*CLASS_W +: CLASS_W] = active ? m : '0;
        assign info_o[l*INFO_W +: INFO_W]   = active ? f : '0;
      end else begin : g_idle
        assign mask_o[l*CLASS_W +: CLASS_W] = '0;
        assign info_o[l*INFO_W +: INFO_W]   = '0;
      end
    end
  end

endmodule

// File: rtl/fpcls_out_stage.sv
module fpcls_out_stage #(
  parameter int unsigned MASK_W = 80,
  parameter int unsigned INFO_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [MASK_W-1:0] mask_i,
  input  logic [INFO_W-1:0] info_i,
  input  logic              err_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [MASK_W-1:0] mask_o,
  output logic [INFO_W-1:0] info_o,
  output logic              err_o
);

  assign in_ready_o = out_ready_i | ~out_valid_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      mask_o      <= '0;
      info_o      <= '0;
      err_o       <= 1'b0;
    end else if (in_valid_i && in_ready_o) begin
      out_valid_o <= 1'b1;
      mask_o      <= mask_i;
      info_o      <= info_i;
      err_o       <= err_i;
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end

  // R10
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(mask_o) && $stable(info_o) && $stable(err_o)));

  // R9
  accept_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> out_valid_o);

  // R9
  drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_valid_i && out_ready_i) |=> !out_valid_o);

endmodule

// File: rtl/fpcls_top.sv
module fpcls_top
  import fpcls_pkg::*;
#(
  parameter int unsigned WIDTH = 64,
  localparam int unsigned LANES  = WIDTH / min_fmt_width(),
  localparam int unsigned MASK_W = LANES * CLASS_W,
  localparam int unsigned FLAG_W = LANES * INFO_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  output logic                 in_ready_o,
  input  logic [FMT_SEL_W-1:0] fmt_i,
  input  logic                 vec_en_i,
  input  logic [WIDTH-1:0]     operand_i,
  output logic                 out_valid_o,
  input  logic                 out_ready_i,
  output logic [MASK_W-1:0]    class_mask_o,
  output logic [FLAG_W-1:0]    info_o,
  output logic                 fmt_err_o
);

  logic [MASK_W-1:0] slice_mask [NUM_FMTS];
  logic [FLAG_W-1:0] slice_info [NUM_FMTS];
  logic [NUM_FMTS-1:0] fmt_sup;

  for (genvar f = 0; f < NUM_FMTS; f++) begin : g_fmt
    fpcls_slice #(
      .WIDTH   (WIDTH),
      .FMT_IDX (f),
      .LANES   (LANES)
    ) u_slice (
      .op_i        (operand_i),
      .vec_en_i    (vec_en_i),
      .mask_o      (slice_mask[f]),
      .info_o      (slice_info[f]),
      .supported_o (fmt_sup[f])
    );
  end

  logic [MASK_W-1:0] sel_mask;
  logic [FLAG_W-1:0] sel_info;
  logic              sel_err;

  always_comb begin
    sel_mask = '0;
    sel_info = '0;
    sel_err  = 1'b1;
    for (int f = 0; f < NUM_FMTS; f++) begin
      if (fmt_i == FMT_SEL_W'(f) && fmt_sup[f]) begin
        sel_mask = slice_mask[f];
        sel_info = slice_info[f];
        sel_err  = 1'b0;
      end
    end
  end

  fpcls_out_stage #(
    .MASK_W (MASK_W),
    .INFO_W (FLAG_W)
  ) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .mask_i      (sel_mask),
    .info_i      (sel_info),
    .err_i       (sel_err),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .mask_o      (class_mask_o),
    .info_o      (info_o),
    .err_o       (fmt_err_o)
  );

  // R1
  err_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && fmt_err_o) |-> (class_mask_o == '0 && info_o == '0));

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    // R2
    lane_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o |-> $onehot0(class_mask_o[l*CLASS_W +: CLASS_W]));

    // R4
    nan_class_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o && info_o[l*INFO_W + INF_NAN]) |->
        (class_mask_o[l*CLASS_W + CLS_SNAN] || class_mask_o[l*CLASS_W + CLS_QNAN]));
  end

endmodule

// File: tb/fpcls_top_bench.sv
`timescale 1ns/1ps
module fpcls_top_bench;

  localparam int W = 64;
  localparam int L = 8;

  logic          clk, rst_n;
  logic          in_valid, in_ready, out_valid, out_ready, vec_en, fmt_err;
  logic [2:0]    fmt;
  logic [W-1:0]  op;
  logic [L*10-1:0] mask;
  logic [L*8-1:0]  info;

  int checks = 0;
  int errors = 0;

  fpcls_top #(.WIDTH(W)) u_fpcls_top (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .fmt_i(fmt), .vec_en_i(vec_en), .operand_i(op), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .class_mask_o(mask), .info_o(info), .fmt_err_o(fmt_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int ew_of(int f);
    case (f) 0: return 8; 1: return 11; 2: return 5; 3: return 5; 4: return 8; default: return 0; endcase
  endfunction
  function automatic int mw_of(int f);
    case (f) 0: return 23; 1: return 52; 2: return 10; 3: return 2; 4: return 7; default: return 0; endcase
  endfunction

  function automatic logic [17:0] ref_lane(logic [63:0] v, int ew, int mw, bit boxed);
    logic [9:0] m; logic [7:0] f; logic [63:0] e, mn; logic s;
    m = '0; f = '0;
    e  = (v >> mw) & ((64'd1 << ew) - 1);
    mn = v & ((64'd1 << mw) - 1);
    s  = v[ew+mw];
    if (!boxed) begin
      m[9] = 1'b1; f[4] = 1'b1; f[6] = 1'b1;
    end else begin
      f[7] = 1'b1;
      if (e == ((64'd1 << ew) - 1)) begin
        if (mn != 0) begin
          f[4] = 1'b1;
          if (v[mw-1]) begin m[9] = 1'b1; f[6] = 1'b1; end
          else begin m[8] = 1'b1; f[5] = 1'b1; end
        end else begin
          f[3] = 1'b1; m[s ? 0 : 7] = 1'b1;
        end
      end else if (e == 0) begin
        if (mn == 0) begin f[2] = 1'b1; m[s ? 3 : 4] = 1'b1; end
        else begin f[1] = 1'b1; m[s ? 2 : 5] = 1'b1; end
      end else begin
        f[0] = 1'b1; m[s ? 1 : 6] = 1'b1;
      end
    end
    return {f, m};
  endfunction

  task automatic expect_of(int f, bit v, logic [63:0] x,
                           output logic [L*10-1:0] em, output logic [L*8-1:0] ei,
                           output logic ee);
    int ew, mw, fw, nl;
    logic [63:0] fmask, lv;
    bit boxed;
    logic [17:0] r;
    em = '0; ei = '0; ee = 1'b0;
    if (f > 4) begin ee = 1'b1; return; end
    ew = ew_of(f); mw = mw_of(f); fw = ew + mw + 1;
    nl = v ? W / fw : 1;
    fmask = (fw == 64) ? '1 : ((64'd1 << fw) - 1);
    boxed = v ? 1'b1 : ((fw == 64) ? 1'b1 : ((x >> fw) == ((64'd1 << (64 - fw)) - 1)));
    for (int l = 0; l < nl; l++) begin
      lv = (x >> (l * fw)) & fmask;
      r = ref_lane(lv, ew, mw, boxed);
      em[l*10 +: 10] = r[9:0];
      ei[l*8 +: 8]   = r[17:10];
    end
  endtask

  // send one operand with out_ready high and check the next beat
  task automatic run_case(string tag, int f, bit v, logic [63:0] x);
    logic [L*10-1:0] em; logic [L*8-1:0] ei; logic ee;
    expect_of(f, v, x, em, ei, ee);
    @(negedge clk);
    fmt = 3'(f); vec_en = v; op = x; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R9 valid"}, 128'(out_valid), 128'(1'b1));
    chk({tag, " mask"}, 128'(mask), 128'(em));
    chk({tag, " info"}, 128'(info), 128'(ei));
    chk({tag, " R1 err"}, 128'(fmt_err), 128'(ee));
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; fmt = '0; vec_en = 1'b0; op = '0;
    repeat (3) @(negedge clk);
    chk("R11 reset valid", 128'(out_valid), 128'(1'b0));
    chk("R9 reset ready", 128'(in_ready), 128'(1'b1));
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_known;
    run_case("R2 fp32 +inf", 0, 1'b0, 64'hFFFFFFFF_7F800000);
    chk("R2 fp32 +inf bit7", 128'(mask[9:0]), 128'(10'h080));
    run_case("R5 fp64 -zero", 1, 1'b0, 64'h80000000_00000000);
    chk("R5 fp64 -zero bit3", 128'(mask[9:0]), 128'(10'h008));
    chk("R3 fp64 zero info", 128'(info[7:0]), 128'(8'h84));
    run_case("R4 fp8 snan", 3, 1'b0, 64'hFFFFFFFF_FFFFFF7D);
    chk("R4 fp8 snan bit8", 128'(mask[9:0]), 128'(10'h100));
    run_case("R7 fp16 unboxed", 2, 1'b0, 64'h00000000_00003C00);
    chk("R7 unboxed qnan", 128'(mask[9:0]), 128'(10'h200));
    chk("R7 unboxed info", 128'(info[7:0]), 128'(8'h50));
  endtask

  task automatic t_scalar;
    run_case("R5 fp32 -norm", 0, 1'b0, 64'hFFFFFFFF_BF800000);
    run_case("R5 fp32 +sub", 0, 1'b0, 64'hFFFFFFFF_00000001);
    run_case("R4 fp32 -qnan", 0, 1'b0, 64'hFFFFFFFF_FFC00000);
    run_case("R4 fp64 snan", 1, 1'b0, 64'h7FF00000_00000001);
    run_case("R4 fp64 -inf", 1, 1'b0, 64'hFFF00000_00000000);
    run_case("R5 fp64 -sub", 1, 1'b0, 64'h800FFFFF_FFFFFFFF);
    run_case("R5 fp16 +zero", 2, 1'b0, 64'hFFFFFFFF_FFFF0000);
    run_case("R5 fp8 -sub", 3, 1'b0, 64'hFFFFFFFF_FFFFFF81);
    run_case("R5 fp16alt +norm", 4, 1'b0, 64'hFFFFFFFF_FFFF3F80);
    run_case("R6 fp16 upper lanes idle", 2, 1'b0, 64'hFFFFFFFF_FFFF7C00);
    chk("R6 lanes 1..7 zero", 128'(mask[79:10]), 128'(0));
    run_case("R7 fp32 near box", 0, 1'b0, 64'h7FFFFFFF_3F800000);
    run_case("R7 fp16alt near box", 4, 1'b0, 64'hFFFFFFFE_FFFF3F80);
  endtask

  task automatic t_vector;
    run_case("R8 fp16 vec", 2, 1'b1, 64'h7E00_0001_BC00_7C00);
    chk("R8 fp16 lane3 qnan", 128'(mask[39:30]), 128'(10'h200));
    run_case("R8 fp8 vec", 3, 1'b1, 64'h3C01_7E7D_FC7C_8000);
    run_case("R8 fp32 vec", 0, 1'b1, 64'h7FC00000_80000001);
    run_case("R8 fp16alt vec", 4, 1'b1, 64'h7F80_FF81_0080_8000);
    run_case("R8 fp64 vec", 1, 1'b1, 64'h3FF00000_00000000);
    chk("R8 fp64 vec lanes 1..7 zero", 128'(mask[79:10]), 128'(0));
    run_case("R8 fp32 vec unboxed upper", 0, 1'b1, 64'h00000000_00000000);
  endtask

  task automatic t_unsup;
    run_case("R1 code5", 5, 1'b0, 64'hFFFFFFFF_7F800000);
    run_case("R1 code7 vec", 7, 1'b1, 64'h12345678_9ABCDEF0);
    run_case("R1 code4 ok", 4, 1'b0, 64'hFFFFFFFF_FFFF0000);
  endtask

  task automatic t_stall;
    logic [L*10-1:0] ema, emb; logic [L*8-1:0] eia, eib; logic eea, eeb;
    expect_of(2, 1'b1, 64'h0001_8000_7C00_FC00, ema, eia, eea);
    expect_of(0, 1'b0, 64'hFFFFFFFF_3F800000, emb, eib, eeb);
    @(negedge clk);
    out_ready = 1'b0; fmt = 3'd2; vec_en = 1'b1; op = 64'h0001_8000_7C00_FC00; in_valid = 1'b1;
    @(negedge clk);
    chk("R9 stall accept", 128'(out_valid), 128'(1'b1));
    fmt = 3'd0; vec_en = 1'b0; op = 64'hFFFFFFFF_3F800000;
    chk("R9 stall ready low", 128'(in_ready), 128'(1'b0));
    repeat (2) @(negedge clk);
    chk("R10 hold mask", 128'(mask), 128'(ema));
    chk("R10 hold info", 128'(info), 128'(eia));
    chk("R10 hold valid", 128'(out_valid), 128'(1'b1));
    out_ready = 1'b1;
    #1;
    chk("R9 ready follows out_ready", 128'(in_ready), 128'(1'b1));
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 second mask", 128'(mask), 128'(emb));
    chk("R9 second info", 128'(info), 128'(eib));
    @(negedge clk);
    chk("R9 drained", 128'(out_valid), 128'(1'b0));
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_known();
    t_scalar();
    t_vector();
    t_unsup();
    t_stall();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule